// File: doc/BRIEF.md
# DAC Oversampling Ratio Detector

This block works out the oversampling ratio at which the DACs should run. It counts master-clock cycles between two rising edges of a frame-rate reference. It then snaps that count to the nearest supported ratio and reports the ratio as a 3-bit code, together with a valid flag and an error flag. All three reference clocks are assumed to be already synchronised into the master-clock domain.

The reference is picked from the DAC data routing. Primary-interface data is measured against the primary word clock, and secondary-interface data against the secondary word clock. S/PDIF receiver data is normally measured against the sub-frame clock. A mode input switches S/PDIF routing to the primary word clock. This lets every DAC run from one common word clock when some DACs take primary-interface data while the first DAC takes receiver data.

A code is only declared valid after two back-to-back measurements agree. A count outside every tolerance window raises the error flag and leaves the reported code untouched. Changing the effective reference clears the qualification and starts a fresh measurement.

Top module: `dac_osr_detect`

## Requirements
- R1: `osr_code` values 0 to 6 stand for 128, 192, 256, 384, 512, 768 and 1152 master-clock cycles per reference period, in that ascending order.
- R2: A period count within 2 cycles of a supported ratio, either side and inclusive, is accepted as that ratio.
- R3: A count outside every tolerance window sets `osr_err`. It leaves `osr_code` and `osr_valid` unchanged and discards the pending candidate.
- R4: `osr_valid` rises only on the second of two consecutive accepted measurements with the same code. `osr_code` is updated at that moment. An accepted code that differs from the candidate clears `osr_valid`.
- R5: `src_sel` picks the reference as follows: 0 is the primary word clock, 1 is the secondary word clock, 2 is the S/PDIF sub-frame clock, and 3 is the primary word clock.
- R6: With `src_sel` = 2 and `mode_common` = 1, the primary word clock is measured instead of the sub-frame clock.
- R7: A change of the effective reference clears `osr_valid`, `osr_err` and the candidate, and keeps `osr_code`. Counting restarts on the next rising edge of the new reference.
- R8: The period counter saturates at 2047. When it reaches saturation, `osr_err` is set while `osr_valid` and `osr_code` hold.
- R9: During reset and right after it, `osr_code` = 0, `osr_valid` = 0 and `osr_err` = 0.
- R10: Any accepted measurement clears `osr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_wclk | input | 1 | Primary interface word clock, synchronised |
| sec_wclk | input | 1 | Secondary interface word clock, synchronised |
| sfrm_clk | input | 1 | S/PDIF sub-frame clock, synchronised |
| src_sel | input | 2 | DAC data source |
| mode_common | input | 1 | Measure the primary word clock for S/PDIF routing |
| osr_code | output | 3 | Encoded oversampling ratio |
| osr_valid | output | 1 | Ratio qualified |
| osr_err | output | 1 | Out-of-range or missing reference |

## Verification
A reference rising edge is seen at the first clock edge where the input is high after a low sample. Any resulting change in code, valid or error is visible right after that same edge. A change of routing clears the flags at the first edge after it. So after a change the valid flag is due no later than three reference periods later, and it is certainly absent one and a half periods in. The bench applies each new period while the block is routed elsewhere, then waits three periods plus margin before sampling at a falling edge. The early-absence case is sampled at 1.5 periods, and saturation is sampled a little more than 2047 cycles after the reference stops.

// File: rtl/dac_osr_pkg.sv
package dac_osr_pkg;

  localparam int unsigned NUM_RATIOS = 7;

  typedef enum logic [1:0] {
    REF_PRI  = 2'd0,
    REF_SEC  = 2'd1,
    REF_SFRM = 2'd2
  } ref_sel_e;

  typedef struct packed {
    logic       hit;
    logic [2:0] code;
  } match_t;

  function automatic int unsigned ratio_of(input logic [2:0] code);
    case (code)
      3'd0: return 128;
      3'd1: return 192;
      3'd2: return 256;
      3'd3: return 384;
      3'd4: return 512;
      3'd5: return 768;
      3'd6: return 1152;
      default: return 0;
    endcase
  endfunction

  function automatic match_t classify(input int unsigned count, input int unsigned tol);
    match_t m;
    m.hit  = 1'b0;
    m.code = 3'd0;
    for (int k = 0; k < NUM_RATIOS; k++) begin
      int unsigned r;
      r = ratio_of(3'(k));
      if ((count + tol >= r) && (count <= r + tol)) begin
        m.hit  = 1'b1;
        m.code = 3'(k);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/osr_ref_select.sv
module osr_ref_select
  import dac_osr_pkg::*;
(
  input  logic       pri_wclk,
  input  logic       sec_wclk,
  input  logic       sfrm_clk,
  input  logic [1:0] src_sel,
  input  logic       mode_common,
  output ref_sel_e   ref_sel,
  output logic       ref_clk
);

  always_comb begin
    case (src_sel)
      2'd1:    ref_sel = REF_SEC;
      2'd2:    ref_sel = mode_common ? REF_PRI : REF_SFRM;
      default: ref_sel = REF_PRI;
    endcase
  end

  always_comb begin
    case (ref_sel)
      REF_SEC:  ref_clk = sec_wclk;
      REF_SFRM: ref_clk = sfrm_clk;
      default:  ref_clk = pri_wclk;
    endcase
  end

endmodule

// File: rtl/osr_period_counter.sv
module osr_period_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             restart,
  output logic             meas_ev,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             sat_ev
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             ref_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise     = ref_clk & ~ref_q;
  assign meas_ev  = rise & armed & ~restart;
  assign meas_cnt = cnt;
  assign sat_ev   = armed & ~rise & ~restart & (cnt == CNT_MAX - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_q <= ref_clk;
      if (restart) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (rise) begin
        armed <= 1'b1;
        cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (armed && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/osr_qualifier.sv
module osr_qualifier
  import dac_osr_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned TOL   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             meas_ev,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic             sat_ev,
  output logic [2:0]       osr_code,
  output logic             osr_valid,
  output logic             osr_err,
  output logic             meas_hit
);

  match_t     m;
  logic [2:0] cand;
  logic       cand_v;

  assign m        = classify(int'(meas_cnt), TOL);
  assign meas_hit = m.hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osr_code  <= 3'd0;
      osr_valid <= 1'b0;
      osr_err   <= 1'b0;
      cand      <= 3'd0;
      cand_v    <= 1'b0;
    end else if (restart) begin
      osr_valid <= 1'b0;
      osr_err   <= 1'b0;
      cand_v    <= 1'b0;
    end else if (meas_ev) begin
      if (m.hit) begin
        osr_err <= 1'b0;
        if (cand_v && cand == m.code) begin
          osr_valid <= 1'b1;
          osr_code  <= m.code;
        end else begin
          cand      <= m.code;
          cand_v    <= 1'b1;
          osr_valid <= 1'b0;
        end
      end else begin
        osr_err <= 1'b1;
        cand_v  <= 1'b0;
      end
    end else if (sat_ev) begin
      osr_err <= 1'b1;
      cand_v  <= 1'b0;
    end
  end

endmodule

// File: rtl/dac_osr_detect.sv
module dac_osr_detect
  import dac_osr_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned TOL   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_wclk,
  input  logic       sec_wclk,
  input  logic       sfrm_clk,
  input  logic [1:0] src_sel,
  input  logic       mode_common,
  output logic [2:0] osr_code,
  output logic       osr_valid,
  output logic       osr_err
);

  ref_sel_e         ref_sel;
  ref_sel_e         ref_sel_q;
  logic             ref_clk;
  logic             restart;
  logic             meas_ev;
  logic             sat_ev;
  logic             meas_hit;
  logic [CNT_W-1:0] meas_cnt;

  osr_ref_select u_sel (
    .pri_wclk    (pri_wclk),
    .sec_wclk    (sec_wclk),
    .sfrm_clk    (sfrm_clk),
    .src_sel     (src_sel),
    .mode_common (mode_common),
    .ref_sel     (ref_sel),
    .ref_clk     (ref_clk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ref_sel_q <= REF_PRI;
    else        ref_sel_q <= ref_sel;
  end

  assign restart = (ref_sel != ref_sel_q);

  osr_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_clk  (ref_clk),
    .restart  (restart),
    .meas_ev  (meas_ev),
    .meas_cnt (meas_cnt),
    .sat_ev   (sat_ev)
  );

  osr_qualifier #(.CNT_W(CNT_W), .TOL(TOL)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .meas_ev   (meas_ev),
    .meas_cnt  (meas_cnt),
    .sat_ev    (sat_ev),
    .osr_code  (osr_code),
    .osr_valid (osr_valid),
    .osr_err   (osr_err),
    .meas_hit  (meas_hit)
  );

endmodule

// File: rtl/osr_checker.sv
module osr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       restart,
  input logic       meas_ev,
  input logic       meas_hit,
  input logic       sat_ev,
  input logic [2:0] osr_code,
  input logic       osr_valid,
  input logic       osr_err
);

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    osr_valid |-> (osr_code <= 3'd6)); // R1

  AST_VALID_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osr_valid) |-> $past(meas_ev)); // R4

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ev && !meas_hit && !restart) |=> (osr_err && $stable(osr_code) && $stable(osr_valid))); // R3

  AST_CODE_ONLY_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ev |=> $stable(osr_code)); // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!osr_valid && !osr_err)); // R7

  AST_SAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    sat_ev |=> (osr_err && $stable(osr_code))); // R8

  AST_HIT_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ev && meas_hit) |=> !osr_err); // R10

endmodule

bind dac_osr_detect osr_checker u_osr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .meas_ev   (meas_ev),
  .meas_hit  (meas_hit),
  .sat_ev    (sat_ev),
  .osr_code  (osr_code),
  .osr_valid (osr_valid),
  .osr_err   (osr_err)
);

// File: tb/dac_osr_detect_bench.sv
`timescale 1ns/1ps
module dac_osr_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pri_wclk = 1'b0, sec_wclk = 1'b0, sfrm_clk = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic       mode_common = 1'b0;
  logic [2:0] osr_code;
  logic       osr_valid, osr_err;

  int tests = 0, fails = 0;
  int per_pri = 0, per_sec = 0, per_sf = 0;
  int c_pri = 0, c_sec = 0, c_sf = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_osr_detect u_dac_osr_detect (
    .clk(clk), .rst_n(rst_n), .pri_wclk(pri_wclk), .sec_wclk(sec_wclk),
    .sfrm_clk(sfrm_clk), .src_sel(src_sel), .mode_common(mode_common),
    .osr_code(osr_code), .osr_valid(osr_valid), .osr_err(osr_err)
  );

  // reference generators: period p cycles, high for the first p/2, held low when p < 2
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (per_pri < 2) begin c_pri = 0; pri_wclk = 1'b0; end
    else begin c_pri = (c_pri + 1 >= per_pri) ? 0 : c_pri + 1; pri_wclk = (c_pri < per_pri / 2); end
    if (per_sec < 2) begin c_sec = 0; sec_wclk = 1'b0; end
    else begin c_sec = (c_sec + 1 >= per_sec) ? 0 : c_sec + 1; sec_wclk = (c_sec < per_sec / 2); end
    if (per_sf < 2) begin c_sf = 0; sfrm_clk = 1'b0; end
    else begin c_sf = (c_sf + 1 >= per_sf) ? 0 : c_sf + 1; sfrm_clk = (c_sf < per_sf / 2); end
  end

  // bench's own ratio table: 128 times 1, 1.5, 2, 3, 4, 6, 9
  function automatic int exp_ratio(input int k);
    int mul2[7] = '{2, 3, 4, 6, 8, 12, 18};
    return 64 * mul2[k];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] code, input logic v, input logic e,
                       input logic [2:0] xcode, input logic xv, input logic xe);
    tests++;
    if (code !== xcode || v !== xv || e !== xe) begin
      fails++;
      $display("FAIL %s: code/valid/err = %0d/%0b/%0b expected %0d/%0b/%0b", req, code, v, e, xcode, xv, xe);
    end
  endtask

  initial begin
    wait_cyc(190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] last_good;
    last_good = 3'd0;
    wait_cyc(5);
    check("R9 in reset", osr_code, osr_valid, osr_err, 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R9 after reset", osr_code, osr_valid, osr_err, 3'd0, 1'b0, 1'b0);

    // R1 R2 R3 R5: sweep every ratio at offsets -3,-2,0,+2,+3 on the primary clock
    for (int k = 0; k < 7; k++) begin
      for (int oi = 0; oi < 5; oi++) begin
        int offs[5] = '{-3, -2, 0, 2, 3};
        int n;
        bit inr;
        n = exp_ratio(k) + offs[oi];
        inr = (offs[oi] >= -2 && offs[oi] <= 2);
        src_sel = 2'd1;
        per_pri = n;
        wait_cyc(2 * n);
        src_sel = 2'd0;
        wait_cyc(3 * n + 20);
        if (inr) begin
          last_good = 3'(k);
          check("R1 R2 in-range ratio", osr_code, osr_valid, osr_err, 3'(k), 1'b1, 1'b0);
        end else
          check("R3 out-of-range holds code", osr_code, osr_valid, osr_err, last_good, 1'b0, 1'b1);
      end
    end

    // R4: only one measurement 1.5 periods after a change
    src_sel = 2'd1; per_pri = 384; wait_cyc(800);
    src_sel = 2'd0; wait_cyc(576);
    check("R4 no valid after one measurement", osr_code, osr_valid, osr_err, last_good, 1'b0, 1'b0);
    wait_cyc(1200);
    check("R4 valid after two matches", osr_code, osr_valid, osr_err, 3'd3, 1'b1, 1'b0);

    // R5: secondary word clock
    per_sec = 192; wait_cyc(5);
    src_sel = 2'd1; wait_cyc(3 * 192 + 20);
    check("R5 secondary clock", osr_code, osr_valid, osr_err, 3'd1, 1'b1, 1'b0);

    // R5 R6: S/PDIF routing, sub-frame versus primary
    per_sf = 384; per_pri = 512; wait_cyc(5);
    src_sel = 2'd2; mode_common = 1'b0; wait_cyc(3 * 384 + 20);
    check("R5 sub-frame clock", osr_code, osr_valid, osr_err, 3'd3, 1'b1, 1'b0);
    mode_common = 1'b1; wait_cyc(3 * 512 + 20);
    check("R6 common word clock", osr_code, osr_valid, osr_err, 3'd4, 1'b1, 1'b0);
    src_sel = 2'd3; mode_common = 1'b0; per_pri = 768; wait_cyc(4 * 768 + 20);
    check("R5 code 3 uses primary", osr_code, osr_valid, osr_err, 3'd5, 1'b1, 1'b0);

    // R3 R10: miss with valid held, then recovery without a routing change
    src_sel = 2'd1; per_pri = 256; wait_cyc(600);
    src_sel = 2'd0; wait_cyc(3 * 256 + 20);
    check("R4 valid at 256", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b0);
    per_pri = 260; wait_cyc(3 * 260);
    check("R3 miss keeps valid and code", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b1);
    per_pri = 256; wait_cyc(4 * 256);
    check("R10 hit clears error", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b0);

    // R7: routing change clears flags, keeps code
    src_sel = 2'd1; per_sec = 0; wait_cyc(2);
    check("R7 change clears valid", osr_code, osr_valid, osr_err, 3'd2, 1'b0, 1'b0);

    // R8: reference stops after qualification
    src_sel = 2'd0; wait_cyc(3 * 256 + 20);
    check("R8 prequalify", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b0);
    per_pri = 0; wait_cyc(1500);
    check("R8 no error before saturation", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b0);
    wait_cyc(700);
    check("R8 saturation error", osr_code, osr_valid, osr_err, 3'd2, 1'b1, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule